// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block sets the low-power state of a small 8-bit microcontroller. Software writes a mode register through a simple write port. From that register the block drives a clock enable for the CPU, a clock enable for the peripherals, a free-running divide-by-32 enable strobe, and a run request for the oscillator. It supports three states. Idle stops the CPU and keeps the peripherals running. Slow-down runs everything on one clock edge in thirty-two. Power-down stops the oscillator entirely.

Idle ends when the interrupt controller reports a pending enabled interrupt. Slow-down ends only when software writes its bit back to zero. Power-down ends on an external active-low wake pin, which is sampled in a separate always-running wake clock domain because the main clock is stopped. The reset input, asynchronous and active low, ends every state at once and clears all three mode bits.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset all mode bits are clear: the CPU and peripheral enables are high on every cycle, `osc_run_o` is high, and `slow_stb_o` pulses once every 32 clock cycles.
- R2: A write with bit 0 set (and bits 1 and 4 clear) enters idle. The CPU enable stays low and the peripheral enable stays high on every cycle.
- R3: While idle, a high `irq_pend_i` clears the idle bit at the next clock edge. This also happens when a register write lands in the same cycle; the other bits then take the written values.
- R4: A write with bit 4 set enters slow-down. Both enables are high only in the cycles in which `slow_stb_o` is high, which is once in every 32 clock cycles.
- R5: A write with bits 0 and 4 both set gives the combined state. The CPU enable stays low and the peripheral enable follows `slow_stb_o`.
- R6: The slow-down bit changes only through a register write or reset. An interrupt leaves it set, including an interrupt that ends idle.
- R7: A write with bit 1 set enters power-down. `osc_run_o` and both enables go low. When bits 0 and 1 are written together, power-down wins and the idle bit stays clear.
- R8: In power-down, a low level on `wake_pin_ni` held for at least two wake clock periods raises `osc_run_o` and clears bit 1, and the slow-down bit is kept. A low pulse of one wake clock period is ignored.
- R9: Asserting reset during power-down raises `osc_run_o` without waiting for any clock.
- R10: Written bits other than 0, 1 and 4 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock; stops while `osc_run_o` is low |
| wake_clk_i | input | 1 | Free-running low-rate clock for the wake pin |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Mode register write strobe |
| wr_data_i | input | 8 | Mode register write data (bit 0 idle, bit 1 power-down, bit 4 slow-down) |
| irq_pend_i | input | 1 | An enabled interrupt is pending |
| wake_pin_ni | input | 1 | External active-low wake pin |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| slow_stb_o | output | 1 | One-cycle strobe every 32 clock cycles |
| osc_run_o | output | 1 | Oscillator run request |

## Verification
Two updates can reach the mode register on the same clock edge: the hardware clearing of the idle bit by a pending interrupt, and a software write. The bench enters idle, then in one cycle raises `irq_pend_i` and writes the slow-down bit. It then expects the idle bit to be cleared and the slow-down bit to be set, and judges this from the enable counts over a 64-cycle window. A second race is handled the same way: idle and power-down are requested in one write, and the bench checks the result after waking through the pin.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  localparam int REG_W    = 8;
  localparam int IDLE_BIT = 0;
  localparam int PD_BIT   = 1;
  localparam int SLOW_BIT = 4;

  typedef struct packed {
    logic slow;
    logic pd;
    logic idle;
  } mode_t;
endpackage

// File: rtl/pwr_bit_sync.sv
module pwr_bit_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], d_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= {STAGES{RST_VAL}};
    else         sh_q <= sh_d;
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/pwr_slow_div.sv
module pwr_slow_div #(
  parameter int DIV_W = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic stb_o
);
  localparam logic [DIV_W-1:0] LAST = '1;

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;

  always_comb cnt_d = cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign stb_o = (cnt_q == LAST);

  // R4: the strobe is never high on two consecutive edges
  a_r4_stb_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |=> !stb_o);
endmodule

// File: rtl/pwr_wake_det.sv
module pwr_wake_det #(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD        = 2
) (
  input  logic wclk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  input  logic armed_i,
  output logic hit_o
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] HOLD_C = CW'(HOLD);
  localparam logic [CW-1:0] PRE_C  = CW'(HOLD - 1);

  logic          pin_s;
  logic [CW-1:0] low_q;
  logic [CW-1:0] low_d;
  logic          det;
  logic          hit_q;
  logic          hit_d;

  pwr_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk_i(wclk_i), .rst_ni(rst_ni), .d_i(pin_ni), .q_o(pin_s));

  always_comb begin
    det   = !pin_s && (low_q >= PRE_C);
    if (pin_s)                low_d = '0;
    else if (low_q == HOLD_C) low_d = low_q;
    else                      low_d = low_q + 1'b1;
    hit_d = armed_i && (hit_q || det);
  end

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q <= '0;
      hit_q <= 1'b0;
    end else begin
      low_q <= low_d;
      hit_q <= hit_d;
    end
  end

  assign hit_o = hit_q;

  // R8: a wake hit only appears after the synchronised pin was seen low
  a_r8_hit_after_low: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $rose(hit_q) |-> !$past(pin_s));
  // R8: the hit is dropped once power-down is no longer armed
  a_r8_hit_disarm: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !armed_i |=> !hit_q);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int DIV_W       = 5,
  parameter int SYNC_STAGES = 2,
  parameter int WAKE_HOLD   = 2
) (
  input  logic             clk_i,
  input  logic             wake_clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             irq_pend_i,
  input  logic             wake_pin_ni,
  output logic             cpu_clk_en_o,
  output logic             per_clk_en_o,
  output logic             slow_stb_o,
  output logic             osc_run_o
);
  localparam logic [REG_W-1:0] USED_MASK =
    REG_W'((1 << IDLE_BIT) | (1 << PD_BIT) | (1 << SLOW_BIT));

  logic  rst_c_n;
  logic  rst_w_n;
  logic  pd_armed;
  logic  wake_hit;
  logic  wake_seen;
  logic  stb;
  logic  tick;
  mode_t mode_q;
  mode_t mode_d;
  logic  unused_wr_bits;

  assign unused_wr_bits = ^(wr_data_i & ~USED_MASK);

  pwr_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_clk (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(1'b1), .q_o(rst_c_n));

  pwr_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_wake (
    .clk_i(wake_clk_i), .rst_ni(rst_ni), .d_i(1'b1), .q_o(rst_w_n));

  pwr_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pd_to_wake (
    .clk_i(wake_clk_i), .rst_ni(rst_w_n), .d_i(mode_q.pd), .q_o(pd_armed));

  pwr_wake_det #(.SYNC_STAGES(SYNC_STAGES), .HOLD(WAKE_HOLD)) u_wake (
    .wclk_i(wake_clk_i), .rst_ni(rst_w_n), .pin_ni(wake_pin_ni),
    .armed_i(pd_armed), .hit_o(wake_hit));

  pwr_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_wake_to_clk (
    .clk_i(clk_i), .rst_ni(rst_c_n), .d_i(wake_hit), .q_o(wake_seen));

  pwr_slow_div #(.DIV_W(DIV_W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_c_n), .stb_o(stb));

  // next state: software write first, hardware clears override it
  always_comb begin
    mode_d = mode_q;
    if (wr_en_i) begin
      mode_d.slow = wr_data_i[SLOW_BIT];
      mode_d.pd   = wr_data_i[PD_BIT];
      mode_d.idle = wr_data_i[IDLE_BIT] & ~wr_data_i[PD_BIT];
    end
    if (mode_q.idle && !mode_q.pd && irq_pend_i) mode_d.idle = 1'b0;
    if (mode_q.pd && wake_seen)                  mode_d.pd   = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_c_n) begin
    if (!rst_c_n) mode_q <= '0;
    else          mode_q <= mode_d;
  end

  always_comb begin
    tick         = mode_q.slow ? stb : 1'b1;
    cpu_clk_en_o = tick & ~mode_q.idle & ~mode_q.pd;
    per_clk_en_o = tick & ~mode_q.pd;
    osc_run_o    = ~mode_q.pd | wake_hit;
  end

  assign slow_stb_o = stb;

  // R3: a pending interrupt ends idle on the next edge
  a_r3_irq_ends_idle: assert property (@(posedge clk_i) disable iff (!rst_c_n)
    (mode_q.idle && !mode_q.pd && irq_pend_i) |=> !mode_q.idle);
  // R6: without a write the slow-down bit never drops
  a_r6_slow_holds: assert property (@(posedge clk_i) disable iff (!rst_c_n)
    (mode_q.slow && !wr_en_i) |=> mode_q.slow);
  // R7: power-down wins over idle in one write
  a_r7_pd_wins: assert property (@(posedge clk_i) disable iff (!rst_c_n)
    (wr_en_i && wr_data_i[IDLE_BIT] && wr_data_i[PD_BIT]) |=> (mode_q.pd && !mode_q.idle));
  // R4: in slow-down peripheral enables are isolated single cycles
  a_r4_slow_rate: assert property (@(posedge clk_i) disable iff (!rst_c_n)
    (mode_q.slow && !wr_en_i && per_clk_en_o) |=> !per_clk_en_o);
  // R2: idle keeps the CPU enable low
  a_r2_idle_cpu_off: assert property (@(posedge clk_i) disable iff (!rst_c_n)
    mode_q.idle |-> !cpu_clk_en_o);
endmodule

// File: tb/pwr_mode_ctrl_tb_top.sv
module pwr_mode_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       wclk = 1'b0;
  logic       rst_n;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       irq = 1'b0;
  logic       pin = 1'b1;
  logic       cpu_en, per_en, stb, osc_run;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  pwr_mode_ctrl dut_i (
    .clk_i(clk), .wake_clk_i(wclk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .irq_pend_i(irq),
    .wake_pin_ni(pin), .cpu_clk_en_o(cpu_en), .per_clk_en_o(per_en),
    .slow_stb_o(stb), .osc_run_o(osc_run));

  always #10 wclk = ~wclk;
  // 125 MHz oscillator model that halts low while the run request is low
  always begin
    #4;
    if (osc_run !== 1'b0 || clk) clk = ~clk;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    #30;
    chk("R9 osc_run in reset", int'(osc_run), 1);
    @(negedge wclk) rst_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk) begin wr_en = 1'b1; wr_data = v; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic pulse_irq();
    @(negedge clk) irq = 1'b1;
    @(negedge clk) irq = 1'b0;
  endtask

  task automatic wake_pulse(input int n);
    @(negedge wclk) pin = 1'b0;
    repeat (n) @(negedge wclk);
    pin = 1'b1;
  endtask

  // observe 64 cycles; expected counts follow from the idle/slow bits
  task automatic check_mode(input string req, input bit idle, input bit slow);
    int c = 0, p = 0, s = 0, bad = 0;
    repeat (64) @(negedge clk) begin
      c += int'(cpu_en);
      p += int'(per_en);
      s += int'(stb);
      if (slow && (cpu_en || per_en) && !stb) bad++;
    end
    chk({req, " cpu enables"}, c, idle ? 0 : (slow ? 2 : 64));
    chk({req, " per enables"}, p, slow ? 2 : 64);
    chk({req, " strobes"}, s, 2);
    chk({req, " off-strobe enables"}, bad, 0);
    chk({req, " osc_run"}, int'(osc_run), 1);
  endtask

  initial begin
    rst_n = 1'b0;
    // R1: reset state
    apply_reset();
    check_mode("R1", 1'b0, 1'b0);

    // sweep all combinations of the three mode bits with noise bits (R10)
    for (int m = 0; m < 8; m++) begin
      logic [7:0] v;
      string lbl;
      v = (8'(m[2]) << 4) | (8'(m[1]) << 1) | 8'(m[0]) | (8'(m * 37) & 8'hEC);
      lbl = (m[0] && m[2]) ? "R5" : m[0] ? "R2" : m[2] ? "R4" : "R10";
      apply_reset();
      wr(v);
      if (m[1]) begin
        chk("R7 osc stopped", int'(osc_run), 0);
        chk("R7 cpu off", int'(cpu_en), 0);
        chk("R7 per off", int'(per_en), 0);
        repeat (6) @(negedge wclk);
        chk("R7 osc still stopped", int'(osc_run), 0);
        wake_pulse(4);
        wait (osc_run === 1'b1);
        repeat (8) @(negedge clk);
        // idle never survives a combined write: R7 priority, R8 exit
        check_mode(m[0] ? "R7" : "R8", 1'b0, m[2]);
      end else begin
        check_mode(lbl, m[0], m[2]);
      end
      pulse_irq();
      check_mode(m[2] ? "R6" : "R3", 1'b0, m[2]);
      wr(8'(m * 37) & 8'hEC);
      check_mode("R6 cleared", 1'b0, 1'b0);
    end

    // R8: a single wake-clock low pulse is ignored
    apply_reset();
    wr(8'h02);
    repeat (6) @(negedge wclk);
    wake_pulse(1);
    repeat (12) @(negedge wclk);
    chk("R8 short pulse", int'(osc_run), 0);
    // R9: reset during power-down restarts the oscillator without a clock
    rst_n = 1'b0;
    #2;
    chk("R9 async osc_run", int'(osc_run), 1);
    @(negedge wclk) rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check_mode("R9", 1'b0, 1'b0);

    // R3: interrupt and write on the same edge
    wr(8'h01);
    @(negedge clk) begin wr_en = 1'b1; wr_data = 8'h11; irq = 1'b1; end
    @(negedge clk) begin wr_en = 1'b0; irq = 1'b0; end
    check_mode("R3 same-cycle", 1'b0, 1'b1);

    // R6: interrupt outside idle leaves slow-down set
    apply_reset();
    wr(8'h10);
    pulse_irq();
    check_mode("R6 irq", 1'b0, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule